// File: doc/BRIEF.md
# Serial Configuration Register Loader

This block receives a 32-bit transmitter configuration word over three wires: a frame enable, a data line shared with transmit modulation, and a serial clock. All three pins are synchronized into a faster system clock domain, and their edges are detected there. Bits are shifted in most significant bit first, one per rising serial-clock edge. The whole word becomes active on the falling serial-clock edge that ends the last bit.

The two leading fields, clock-only mode and band select, become active early. This happens on the falling edge that ends the second bit. Once a frame is complete, further serial clock edges are ignored. The data line then acts as the modulation input, and a modulation frequency word is derived from the frequency and deviation fields.

A mode controller starts a new frame with a one-cycle request. The loader clears its progress and is ready for the next word. The fields already in force stay active until that next word is committed.

Top module: `cfg_serial_loader`

## Requirements
- R1: A committed frame drives the field outputs from the word as received, first bit = bit 31. The layout is: bit 31 clock-only mode; bit 30 band select; bits 29..15 frequency word; bits 14..7 FSK deviation; bit 6 divide-by-4 select; bits 5..2 power code; bit 1 ASK (1) or FSK (0); bit 0 clock output enable.
- R2: A data bit is taken only on a rising serial-clock edge while the frame enable is high. Rising edges with the enable low do not advance the frame.
- R3: The word becomes active only on the falling serial-clock edge after the 32nd bit. At that edge `prog_done` pulses for one system cycle and `cfg_loaded` goes high. The field outputs update on the following cycle.
- R4: On the falling edge after the 2nd bit, `part_prog` pulses exactly once per frame. `clk_only_mode` and `band_high` take the first two bits, and all other fields keep their previous values.
- R5: While `cfg_loaded` is high, serial clock edges change no field and raise no strobe.
- R6: `mod_data` equals the synchronized data line while `cfg_loaded` is high, and is 0 otherwise.
- R7: `mod_freq` is computed from the active fields. In FSK mode it is freq + dev when `mod_data` is 1 and freq when `mod_data` is 0. In ASK mode it is freq + floor(dev/2). It is 16 bits wide and does not wrap.
- R8: A `new_frame` pulse clears frame progress and `cfg_loaded`. The active fields are kept until the next commit.
- R9: If `new_frame` arrives in the same system cycle as the final falling edge, the restart wins. No commit happens and no `prog_done` pulse is raised.
- R10: After reset, all field outputs, strobes, `cfg_loaded`, `mod_data` and `mod_freq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| new_frame | input | 1 | One-cycle request from the mode controller to start a new frame |
| ser_en | input | 1 | Frame enable pin (asynchronous) |
| ser_dat | input | 1 | Serial data / modulation pin (asynchronous) |
| ser_clk | input | 1 | Serial clock pin (asynchronous) |
| part_prog | output | 1 | Pulse: first two bits committed |
| prog_done | output | 1 | Pulse: full word committed |
| cfg_loaded | output | 1 | Frame complete, serial clock locked out |
| clk_only_mode | output | 1 | Clock-only mode field |
| band_high | output | 1 | Band select field |
| freq_word | output | 15 | Frequency word field |
| fsk_dev | output | 8 | FSK deviation field |
| clk_div4 | output | 1 | Clock divider select (1 = divide by 4) |
| pwr_code | output | 4 | Output power code field |
| ask_mode | output | 1 | Modulation type (1 = ASK, 0 = FSK) |
| clk_out_en | output | 1 | Clock output enable field |
| mod_data | output | 1 | Modulation data after the frame |
| mod_freq | output | 16 | Decoded modulation frequency word |

## Verification
The commit on the final falling edge and a restart request from the mode controller can fall in the same system cycle. The bench provokes this by counting the two synchronizer stages plus the edge detector after the serial clock drops, then pulsing `new_frame` in exactly the cycle in which the fall is acted on. It judges the outcome at the ports: `prog_done` never pulses, `cfg_loaded` stays low, and the fields keep the previous word. A full frame sent afterwards must still commit normally.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
   localparam int FREQ_W = 15;
   localparam int DEV_W  = 8;
   localparam int PWR_W  = 4;

   // packed MSB first: matches the serial order of the frame
   typedef struct packed {
      logic              clk_only;
      logic              band_hi;
      logic [FREQ_W-1:0] freq;
      logic [DEV_W-1:0]  dev;
      logic              div4;
      logic [PWR_W-1:0]  pwr;
      logic              ask;
      logic              clk_en;
   } cfg_t;

   localparam int CFG_BITS   = $bits(cfg_t);
   localparam int EARLY_BITS = 2;
   localparam int MODF_W     = ((FREQ_W > DEV_W) ? FREQ_W : DEV_W) + 1;
endpackage

// File: rtl/cfgl_sync.sv
module cfgl_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cfgl_sync: STAGES must be at least 2");
   end

   logic [STAGES:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i <= STAGES; i++) begin
            chain[i] <= chain[i-1];
         end
      end
   end

   assign q    = chain[STAGES-1];
   assign rise = chain[STAGES-1] & ~chain[STAGES];
   assign fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/cfgl_shift.sv
module cfgl_shift #(
   parameter int FRAME_BITS = 32,
   parameter int EARLY_BITS = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  restart,
   input  logic                  en_s,
   input  logic                  dat_s,
   input  logic                  sclk_rise,
   input  logic                  sclk_fall,
   output logic [FRAME_BITS-1:0] shreg,
   output logic                  early_pulse,
   output logic                  done_pulse,
   output logic                  loaded
);
   localparam int CNT_W = $clog2(FRAME_BITS + 1);
   localparam logic [CNT_W-1:0] FULL  = CNT_W'(FRAME_BITS);
   localparam logic [CNT_W-1:0] EARLY = CNT_W'(EARLY_BITS);

   if (EARLY_BITS < 1 || EARLY_BITS >= FRAME_BITS) begin : g_bad_early
      $error("cfgl_shift: EARLY_BITS out of range");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt         <= '0;
         shreg       <= '0;
         early_pulse <= 1'b0;
         done_pulse  <= 1'b0;
         loaded      <= 1'b0;
      end else if (restart) begin
         cnt         <= '0;
         shreg       <= '0;
         early_pulse <= 1'b0;
         done_pulse  <= 1'b0;
         loaded      <= 1'b0;
      end else begin
         early_pulse <= 1'b0;
         done_pulse  <= 1'b0;
         if (sclk_rise && en_s && !loaded && cnt < FULL) begin
            shreg <= {shreg[FRAME_BITS-2:0], dat_s};
            cnt   <= cnt + 1'b1;
         end
         if (sclk_fall && !loaded) begin
            if (cnt == EARLY) early_pulse <= 1'b1;
            if (cnt == FULL) begin
               done_pulse <= 1'b1;
               loaded     <= 1'b1;
            end
         end
      end
   end

   // R2
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= FULL);

   // R5
   lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (loaded && !restart) |=> $stable(shreg));

   // R3
   done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_pulse && !restart) |=> (!done_pulse && loaded));

   // R4
   early_chk: assert property (@(posedge clk) disable iff (!rst_n)
      early_pulse |-> (!loaded && !done_pulse));
endmodule

// File: rtl/cfgl_modfreq.sv
module cfgl_modfreq #(
   parameter int FREQ_W = 15,
   parameter int DEV_W  = 8,
   parameter int OUT_W  = FREQ_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FREQ_W-1:0] freq,
   input  logic [DEV_W-1:0]  dev,
   input  logic              ask,
   input  logic              mdat,
   output logic [OUT_W-1:0]  mod_freq
);
   if (OUT_W <= FREQ_W || OUT_W <= DEV_W) begin : g_bad_width
      $error("cfgl_modfreq: OUT_W too narrow to avoid wrap");
   end

   logic [OUT_W-1:0] offs;

   always_comb begin
      if (ask)       offs = OUT_W'(dev >> 1);
      else if (mdat) offs = OUT_W'(dev);
      else           offs = '0;
      mod_freq = OUT_W'(freq) + offs;
   end

   // R7
   modfreq_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mod_freq >= OUT_W'(freq));
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
   import cfgl_pkg::*;
#(
   parameter int FRAME_BITS  = CFG_BITS,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              new_frame,
   input  logic              ser_en,
   input  logic              ser_dat,
   input  logic              ser_clk,
   output logic              part_prog,
   output logic              prog_done,
   output logic              cfg_loaded,
   output logic              clk_only_mode,
   output logic              band_high,
   output logic [FREQ_W-1:0] freq_word,
   output logic [DEV_W-1:0]  fsk_dev,
   output logic              clk_div4,
   output logic [PWR_W-1:0]  pwr_code,
   output logic              ask_mode,
   output logic              clk_out_en,
   output logic              mod_data,
   output logic [MODF_W-1:0] mod_freq
);
   if (FRAME_BITS != CFG_BITS) begin : g_bad_frame
      $error("cfg_serial_loader: FRAME_BITS must equal the field total");
   end

   localparam int PIN_W = 3;
   localparam int P_CLK = 0;
   localparam int P_DAT = 1;
   localparam int P_EN  = 2;

   logic [PIN_W-1:0]      pins_q, pins_rise, pins_fall;
   logic [FRAME_BITS-1:0] shreg;
   logic                  early_pulse, done_pulse, loaded;
   cfg_t                  cfg;

   cfgl_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ser_en, ser_dat, ser_clk}),
      .q     (pins_q),
      .rise  (pins_rise),
      .fall  (pins_fall)
   );

   cfgl_shift #(.FRAME_BITS(FRAME_BITS), .EARLY_BITS(EARLY_BITS)) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .restart     (new_frame),
      .en_s        (pins_q[P_EN]),
      .dat_s       (pins_q[P_DAT]),
      .sclk_rise   (pins_rise[P_CLK]),
      .sclk_fall   (pins_fall[P_CLK]),
      .shreg       (shreg),
      .early_pulse (early_pulse),
      .done_pulse  (done_pulse),
      .loaded      (loaded)
   );

   // active configuration: leading fields early, whole word at commit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (done_pulse) begin
         cfg <= cfg_t'(shreg);
      end else if (early_pulse) begin
         {cfg.clk_only, cfg.band_hi} <= shreg[EARLY_BITS-1:0];
      end
   end

   assign part_prog     = early_pulse;
   assign prog_done     = done_pulse;
   assign cfg_loaded    = loaded;
   assign clk_only_mode = cfg.clk_only;
   assign band_high     = cfg.band_hi;
   assign freq_word     = cfg.freq;
   assign fsk_dev       = cfg.dev;
   assign clk_div4      = cfg.div4;
   assign pwr_code      = cfg.pwr;
   assign ask_mode      = cfg.ask;
   assign clk_out_en    = cfg.clk_en;
   assign mod_data      = loaded & pins_q[P_DAT];

   cfgl_modfreq #(.FREQ_W(FREQ_W), .DEV_W(DEV_W), .OUT_W(MODF_W)) u_modf (
      .clk      (clk),
      .rst_n    (rst_n),
      .freq     (cfg.freq),
      .dev      (cfg.dev),
      .ask      (cfg.ask),
      .mdat     (mod_data),
      .mod_freq (mod_freq)
   );

   // R6
   moddata_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_loaded |-> !mod_data);

   // R9
   restart_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      new_frame |=> (!prog_done && !cfg_loaded));
endmodule

// File: tb/cfg_serial_loader_bench.sv
module cfg_serial_loader_bench;
   localparam int H = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic new_frame = 1'b0;
   logic ser_en = 1'b0;
   logic ser_dat = 1'b0;
   logic ser_clk = 1'b0;
   logic part_prog, prog_done, cfg_loaded, clk_only_mode, band_high;
   logic [14:0] freq_word;
   logic [7:0]  fsk_dev;
   logic        clk_div4;
   logic [3:0]  pwr_code;
   logic        ask_mode, clk_out_en, mod_data;
   logic [15:0] mod_freq;

   int checks = 0;
   int fails = 0;
   int part_cnt = 0;
   int prog_cnt = 0;
   bit done_flag = 0;

   always #2.5 clk = ~clk;

   cfg_serial_loader u_cfg_serial_loader (
      .clk(clk), .rst_n(rst_n), .new_frame(new_frame), .ser_en(ser_en),
      .ser_dat(ser_dat), .ser_clk(ser_clk), .part_prog(part_prog),
      .prog_done(prog_done), .cfg_loaded(cfg_loaded),
      .clk_only_mode(clk_only_mode), .band_high(band_high),
      .freq_word(freq_word), .fsk_dev(fsk_dev), .clk_div4(clk_div4),
      .pwr_code(pwr_code), .ask_mode(ask_mode), .clk_out_en(clk_out_en),
      .mod_data(mod_data), .mod_freq(mod_freq)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (part_prog) part_cnt++;
         if (prog_done) prog_cnt++;
      end
   end

   function automatic logic [31:0] obs_word();
      return {clk_only_mode, band_high, freq_word, fsk_dev, clk_div4,
              pwr_code, ask_mode, clk_out_en};
   endfunction

   // expected modulation word from the field positions in R1 and rules in R7
   function automatic logic [15:0] exp_modf(logic [31:0] w, logic d);
      logic [15:0] f, v;
      f = {1'b0, w[29:15]};
      v = {8'd0, w[14:7]};
      if (w[1]) return f + (v >> 1);
      return d ? f + v : f;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_rise(logic b);
      @(negedge clk) ser_dat = b;
      wait_cyc(H);
      ser_clk = 1'b1;
      wait_cyc(H);
   endtask

   task automatic bit_fall();
      ser_clk = 1'b0;
      wait_cyc(H);
   endtask

   task automatic send_bits(logic [31:0] w, int n);
      for (int i = 31; i > 31 - n; i--) begin
         bit_rise(w[i]);
         bit_fall();
      end
   endtask

   task automatic restart();
      @(negedge clk) new_frame = 1'b1;
      @(negedge clk) new_frame = 1'b0;
   endtask

   task automatic check_modf(string req, logic [31:0] w);
      @(negedge clk) ser_dat = 1'b1;
      wait_cyc(5);
      check({req, " mod_data high"}, {31'd0, mod_data}, 32'd1);
      check({req, " mod_freq dat=1"}, {16'd0, mod_freq}, {16'd0, exp_modf(w, 1'b1)});
      @(negedge clk) ser_dat = 1'b0;
      wait_cyc(5);
      check({req, " mod_data low"}, {31'd0, mod_data}, 32'd0);
      check({req, " mod_freq dat=0"}, {16'd0, mod_freq}, {16'd0, exp_modf(w, 1'b0)});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] w, prev;
      int pc;
      void'($urandom(32'd4242));
      wait_cyc(4);
      // R10 reset state
      check("R10 fields", obs_word(), 32'd0);
      check("R10 loaded", {31'd0, cfg_loaded}, 32'd0);
      check("R10 mod_freq", {16'd0, mod_freq}, 32'd0);
      check("R10 mod_data", {31'd0, mod_data}, 32'd0);
      rst_n = 1'b1;
      wait_cyc(3);
      ser_en = 1'b1;
      restart();

      // R4 leading fields after two bits, rest untouched
      w = $urandom() | 32'hC000_0000;
      w[1] = 1'b0;
      send_bits(w, 2);
      wait_cyc(4);
      check("R4 part_prog count", part_cnt, 1);
      check("R4 early fields", obs_word(), 32'hC000_0000);
      check("R3 no early commit", prog_cnt, 0);

      // R3 nothing before the final fall
      for (int i = 29; i >= 1; i--) begin
         bit_rise(w[i]);
         bit_fall();
      end
      bit_rise(w[0]);
      wait_cyc(4);
      check("R3 not loaded before fall", {31'd0, cfg_loaded}, 32'd0);
      check("R3 fields before fall", obs_word(), 32'hC000_0000);
      bit_fall();
      check("R3 prog_done once", prog_cnt, 1);
      check("R3 loaded", {31'd0, cfg_loaded}, 32'd1);
      check("R1 word", obs_word(), w);
      check("R4 single part_prog", part_cnt, 1);

      // R6 and R7 in FSK mode
      check_modf("R7 fsk", w);

      // R5 further serial clocks ignored
      pc = prog_cnt;
      for (int k = 0; k < 8; k++) begin
         bit_rise(1'($urandom()));
         bit_fall();
      end
      ser_dat = 1'b0;
      check("R5 fields stable", obs_word(), w);
      check("R5 no prog_done", prog_cnt, pc);
      check("R5 no part_prog", part_cnt, 1);

      // random frames, plus directed extremes
      for (int f = 0; f < 6; f++) begin
         prev = w;
         w = $urandom();
         w[1] = f[0];
         if (f == 4) w = 32'h3FFF_FFFF;
         if (f == 5) w = 32'hFFFF_FFFD;
         ser_dat = 1'b1;
         restart();
         wait_cyc(3);
         check("R8 loaded cleared", {31'd0, cfg_loaded}, 32'd0);
         check("R6 gated before frame", {31'd0, mod_data}, 32'd0);
         check("R8 fields kept", obs_word(), prev);
         send_bits(w, 32);
         check("R1 random word", obs_word(), w);
         check_modf(w[1] ? "R7 ask" : "R7 fsk", w);
      end

      // R2 rising edges with enable low are not counted
      prev = w;
      restart();
      @(negedge clk) ser_en = 1'b0;
      wait_cyc(4);
      for (int k = 0; k < 5; k++) begin
         bit_rise(1'b1);
         bit_fall();
      end
      @(negedge clk) ser_en = 1'b1;
      wait_cyc(4);
      w = $urandom();
      send_bits(w, 32);
      check("R2 enable gating", obs_word(), w);

      // R9 restart in the same cycle as the final fall
      prev = w;
      pc = prog_cnt;
      restart();
      w = ~prev;
      send_bits(w, 31);
      bit_rise(w[0]);
      @(negedge clk) ser_clk = 1'b0;
      @(negedge clk);
      @(negedge clk) new_frame = 1'b1;
      @(negedge clk) new_frame = 1'b0;
      wait_cyc(6);
      check("R9 no prog_done", prog_cnt, pc);
      check("R9 not loaded", {31'd0, cfg_loaded}, 32'd0);
      check("R9 fields kept", {obs_word()} & 32'h3FFF_FFFF, prev & 32'h3FFF_FFFF);
      send_bits(w, 32);
      check("R9 next frame commits", obs_word(), w);

      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule